// File: doc/BRIEF.md
# Mains-Rejecting Moving-Sum Sample Filter

This block smooths a stream of signed converter samples with a rectangular moving window. Each accepted sample enters a circular store of depth `WINDOW`, and a running total is adjusted by adding the arriving value and removing the value it displaces. The total and its quotient by `WINDOW` are both presented. When `WINDOW` spans a whole number of power-line periods at the sample rate, the filter has response nulls at the line frequency and every harmonic of it. For example, 20 samples at 1 kHz span one 50 Hz period. For 60 Hz, the window must cover a multiple of about 16.7 ms.

A moving window delays its output by about half its own length, so `WINDOW` is best kept to the shortest whole number of line periods. A control loop rarely wants every sample. A second, decimated output therefore presents one averaged value for every `DECIM` valid window results. With the defaults this gives roughly 30 values per second at 1 kHz.

Top module: `mains_boxcar_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `sumOut` and `avgOut` are zero and `outValid` and `decimValid` are low.
- R2: In the cycle after each cycle with `inValid` high, `sumOut` equals the sum of the most recent `WINDOW` accepted samples. Before `WINDOW` samples have arrived since reset, it equals the sum of all samples accepted so far.
- R3: `sumOut` is `SAMPLE_W + ceil(log2 WINDOW)` bits, two's complement. A full window of the most negative or most positive code is reported exactly, without wrap.
- R4: `avgOut` (`SAMPLE_W` bits, two's complement) is updated with `sumOut` and equals `sumOut / WINDOW`, with the quotient truncated toward zero.
- R5: `outValid` is a one-cycle pulse in the cycle after an accepted sample. It occurs only once at least `WINDOW` samples have been accepted since reset.
- R6: A cycle with `inValid` low is ignored. `inSample` has no effect, `sumOut` and `avgOut` hold, and neither valid output pulses in the following cycle.
- R7: `decimValid` pulses together with every `DECIM`-th `outValid` pulse, counting from the first pulse after reset, so the first one follows sample `WINDOW + DECIM - 1`. `decimAvg` takes the `avgOut` value of that cycle and holds it until the next `decimValid`.
- R8: An input that repeats with a period equal to `WINDOW` samples and sums to zero over one period produces `sumOut = 0` for every valid output.
- R9: Asserting reset in the middle of a stream discards every stored sample. Counting toward R5 and R7 then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Strobe: `inSample` is accepted this cycle |
| inSample | input | SAMPLE_W | Signed input sample |
| outValid | output | 1 | Pulse: window result is complete |
| sumOut | output | SAMPLE_W+clog2(WINDOW) | Signed running sum over the window |
| avgOut | output | SAMPLE_W | Signed window average, truncated toward zero |
| decimValid | output | 1 | Pulse: decimated value updated |
| decimAvg | output | SAMPLE_W | Signed average, held between decimation pulses |

## Verification
Every result is registered once after the accepting edge. `sumOut`, `avgOut`, `outValid`, `decimValid` and `decimAvg` all reflect a sample at the first falling clock edge after the rising edge on which `inValid` was high. The bench drives each sample at a falling edge and compares all five outputs at the next falling edge. It runs that comparison again at every idle falling edge that follows, which confirms that nothing moves and that no pulse appears. The expected sums, truncated quotients and decimation phase come from a sample history kept in the bench. That history is cleared whenever reset is applied.

// File: rtl/mains_boxcar_pkg.sv
package mains_boxcar_pkg;

  // Strobes passed from the sequencing logic to the arithmetic path.
  typedef struct packed {
    logic push;            // a sample is accepted this cycle
    logic windowComplete;  // after this push the window holds WINDOW samples
    logic decimFire;       // this push yields a decimated value
  } boxcarCtrl_t;

endpackage

// File: rtl/mains_boxcar_ctrl.sv
module mains_boxcar_ctrl
  import mains_boxcar_pkg::*;
#(
  parameter int WINDOW = 20,
  parameter int DECIM  = 33,
  parameter int PTR_W  = $clog2(WINDOW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output boxcarCtrl_t      ctrl,
  output logic [PTR_W-1:0] wrPtr
);

  localparam int FILL_W = $clog2(WINDOW + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(WINDOW);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WINDOW - 1);
  localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(WINDOW - 1);

  logic [FILL_W-1:0] fillCount;
  logic              windowComplete;

  assign windowComplete = (fillCount >= FILL_LAST);

  // Saturating count of samples accepted since reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
    end else if (inValid && fillCount != FILL_FULL) begin
      fillCount <= fillCount + 1'b1;
    end
  end

  // Ring position of the oldest sample (the one about to be replaced).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (inValid) begin
      wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
    end
  end

  logic decimFire;

  generate
    if (DECIM == 1) begin : g_noDecim
      assign decimFire = inValid && windowComplete;
    end else begin : g_decim
      localparam int DEC_W = $clog2(DECIM);
      localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECIM - 1);
      logic [DEC_W-1:0] decimCount;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          decimCount <= '0;
        end else if (inValid && windowComplete) begin
          decimCount <= (decimCount == DEC_LAST) ? '0 : decimCount + 1'b1;
        end
      end

      assign decimFire = inValid && windowComplete && (decimCount == DEC_LAST);
    end
  endgenerate

  always_comb begin
    ctrl.push           = inValid;
    ctrl.windowComplete = windowComplete;
    ctrl.decimFire      = decimFire;
  end

endmodule

// File: rtl/mains_boxcar_dp.sv
module mains_boxcar_dp
  import mains_boxcar_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WINDOW   = 20,
  parameter int PTR_W    = $clog2(WINDOW),
  parameter int ACC_W    = SAMPLE_W + $clog2(WINDOW)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  boxcarCtrl_t                ctrl,
  input  logic [PTR_W-1:0]           wrPtr,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic                       outValid,
  output logic signed [ACC_W-1:0]    sumOut,
  output logic signed [SAMPLE_W-1:0] avgOut,
  output logic                       decimValid,
  output logic signed [SAMPLE_W-1:0] decimAvg
);

  localparam int EXT_W = ACC_W - SAMPLE_W;
  localparam logic signed [ACC_W:0] WIN_DIV = (ACC_W + 1)'(WINDOW);

  logic signed [SAMPLE_W-1:0] ring [WINDOW];
  logic signed [SAMPLE_W-1:0] leaving;
  logic signed [ACC_W-1:0]    arriveExt;
  logic signed [ACC_W-1:0]    leaveExt;
  logic signed [ACC_W-1:0]    nextSum;
  logic signed [ACC_W:0]      nextSumWide;
  logic signed [SAMPLE_W-1:0] nextAvg;

  always_comb begin
    leaving     = ring[wrPtr];
    arriveExt   = {{EXT_W{inSample[SAMPLE_W-1]}}, inSample};
    leaveExt    = {{EXT_W{leaving[SAMPLE_W-1]}}, leaving};
    // Wrap in the intermediate cancels; the final total always fits ACC_W.
    nextSum     = sumOut + arriveExt - leaveExt;
    nextSumWide = {nextSum[ACC_W-1], nextSum};
    nextAvg     = SAMPLE_W'(nextSumWide / WIN_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WINDOW; i++) begin
        ring[i] <= '0;
      end
      sumOut <= '0;
      avgOut <= '0;
    end else if (ctrl.push) begin
      ring[wrPtr] <= inSample;
      sumOut      <= nextSum;
      avgOut      <= nextAvg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      decimValid <= 1'b0;
      decimAvg   <= '0;
    end else begin
      outValid   <= ctrl.push && ctrl.windowComplete;
      decimValid <= ctrl.decimFire;
      if (ctrl.decimFire) begin
        decimAvg <= nextAvg;
      end
    end
  end

endmodule

// File: rtl/mains_boxcar_filter.sv
module mains_boxcar_filter
  import mains_boxcar_pkg::*;
#(
  parameter  int SAMPLE_W = 12,
  parameter  int WINDOW   = 20,
  parameter  int DECIM    = 33,
  localparam int PTR_W    = $clog2(WINDOW),
  localparam int ACC_W    = SAMPLE_W + $clog2(WINDOW)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic                       outValid,
  output logic signed [ACC_W-1:0]    sumOut,
  output logic signed [SAMPLE_W-1:0] avgOut,
  output logic                       decimValid,
  output logic signed [SAMPLE_W-1:0] decimAvg
);

  boxcarCtrl_t      ctrl;
  logic [PTR_W-1:0] wrPtr;

  mains_boxcar_ctrl #(
    .WINDOW (WINDOW),
    .DECIM  (DECIM),
    .PTR_W  (PTR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl),
    .wrPtr   (wrPtr)
  );

  mains_boxcar_dp #(
    .SAMPLE_W (SAMPLE_W),
    .WINDOW   (WINDOW),
    .PTR_W    (PTR_W),
    .ACC_W    (ACC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .wrPtr      (wrPtr),
    .inSample   (inSample),
    .outValid   (outValid),
    .sumOut     (sumOut),
    .avgOut     (avgOut),
    .decimValid (decimValid),
    .decimAvg   (decimAvg)
  );

endmodule

// File: rtl/mains_boxcar_chk.sv
module mains_boxcar_chk #(
  parameter int SAMPLE_W = 12,
  parameter int WINDOW   = 20,
  parameter int ACC_W    = SAMPLE_W + $clog2(WINDOW)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic signed [SAMPLE_W-1:0] inSample,
  input logic                       outValid,
  input logic signed [ACC_W-1:0]    sumOut,
  input logic signed [SAMPLE_W-1:0] avgOut,
  input logic                       decimValid,
  input logic signed [SAMPLE_W-1:0] decimAvg
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);
  localparam logic signed [ACC_W:0] SUM_MIN =
    -((ACC_W + 1)'(WINDOW) <<< (SAMPLE_W - 1));
  localparam logic signed [ACC_W:0] SUM_MAX =
    (ACC_W + 1)'(WINDOW) * (((ACC_W + 1)'(1) <<< (SAMPLE_W - 1)) - 1);

  logic [CNT_W-1:0]      seen;
  logic signed [ACC_W:0] sumWide;

  assign sumWide = {sumOut[ACC_W-1], sumOut};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen <= '0;
    end else if (inValid && seen != CNT_FULL) begin
      seen <= seen + 1'b1;
    end
  end

  // R5
  valid_follows_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R5
  window_filled_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (seen == CNT_FULL));

  // R6
  idle_holds_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sumOut) && $stable(avgOut) && !outValid));

  // R7
  decim_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    decimValid |-> (outValid && decimAvg == avgOut));

  // R7
  decim_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decimValid |-> $stable(decimAvg));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (sumWide >= SUM_MIN && sumWide <= SUM_MAX));

endmodule

bind mains_boxcar_filter mains_boxcar_chk #(
  .SAMPLE_W (SAMPLE_W),
  .WINDOW   (WINDOW),
  .ACC_W    (ACC_W)
) u_chk (.*);

// File: tb/mains_boxcar_filter_bench.sv
module mains_boxcar_filter_bench;

  localparam int SW  = 8;
  localparam int WIN = 5;
  localparam int DEC = 3;
  localparam int AW  = SW + $clog2(WIN);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [SW-1:0] inSample = '0;
  logic                 outValid;
  logic signed [AW-1:0] sumOut;
  logic signed [SW-1:0] avgOut;
  logic                 decimValid;
  logic signed [SW-1:0] decimAvg;

  int checks = 0;
  int errors = 0;
  int hist[$];
  int lastDecim = 0;

  always #4 clk = ~clk;

  mains_boxcar_filter #(
    .SAMPLE_W (SW),
    .WINDOW   (WIN),
    .DECIM    (DEC)
  ) u_mains_boxcar_filter (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSample   (inSample),
    .outValid   (outValid),
    .sumOut     (sumOut),
    .avgOut     (avgOut),
    .decimValid (decimValid),
    .decimAvg   (decimAvg)
  );

  task automatic expectVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int modelSum();
    int s = 0;
    int k = hist.size();
    int lo = (k > WIN) ? k - WIN : 0;
    for (int i = lo; i < k; i++) s += hist[i];
    return s;
  endfunction

  task automatic checkAll(string req, bit justPushed);
    int k = hist.size();
    int es = modelSum();
    int ea = es / WIN;
    bit ev = justPushed && (k >= WIN);
    bit ed = ev && (((k - WIN + 1) % DEC) == 0);
    if (ed) lastDecim = ea;
    expectVal(req, "sumOut", int'(sumOut), es);
    expectVal(req, "avgOut", int'(avgOut), ea);
    expectVal(req, "outValid", int'(outValid), int'(ev));
    expectVal(req, "decimValid", int'(decimValid), int'(ed));
    expectVal(req, "decimAvg", int'(decimAvg), lastDecim);
  endtask

  // Called at a falling edge; leaves inValid high for back-to-back pushes.
  task automatic pushOne(string req, int v);
    inValid  = 1'b1;
    inSample = SW'(v);
    hist.push_back(v);
    @(negedge clk);
    checkAll(req, 1'b1);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) begin
      inValid  = 1'b0;
      inSample = SW'(8'h5A + i);  // junk that must be ignored
      @(negedge clk);
      checkAll(req, 1'b0);
    end
  endtask

  task automatic doReset(string req);
    rstN = 1'b0;
    inValid = 1'b0;
    hist.delete();
    lastDecim = 0;
    repeat (3) @(negedge clk);
    checkAll(req, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll(req, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset("R1");

    // R2 R4 R5 R7: ramp through the fill and beyond
    for (int v = 1; v <= 12; v++) pushOne("R2", v);
    idle("R6", 2);

    // R6: samples separated by idle cycles carrying junk on inSample
    for (int v = 0; v < 6; v++) begin
      pushOne("R6", -3 * v + 7);
      idle("R6", 2);
    end

    // R4: negative sums, truncation toward zero
    foreach (hist[i]) ;
    for (int v = 0; v < 8; v++) pushOne("R4", (v % 2 == 0) ? -1 : -2);
    idle("R4", 1);

    // R3: full windows of the extreme codes
    for (int v = 0; v < 7; v++) pushOne("R3", 127);
    for (int v = 0; v < 7; v++) pushOne("R3", -128);
    idle("R3", 1);

    // R8: period-5 zero-mean input after a clean start
    doReset("R1");
    for (int v = 0; v < 20; v++) begin
      case (v % 5)
        0: pushOne("R8", 40);
        1: pushOne("R8", 12);
        2: pushOne("R8", -32);
        3: pushOne("R8", -32);
        default: pushOne("R8", 12);
      endcase
    end
    idle("R8", 1);

    // R2 R7: sweep every input code
    for (int v = -128; v <= 127; v++) pushOne("R2", v);
    idle("R7", 1);

    // R9: reset in the middle of a stream, then refill
    for (int v = 0; v < 3; v++) pushOne("R9", 50 + v);
    doReset("R9");
    for (int v = 0; v < 9; v++) pushOne("R9", 9 - 4 * v);
    idle("R9", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule